// File: doc/BRIEF.md
# Bus Channel Serializer Bridge

This block moves the five channels of a request/response memory bus (labelled A to E) across a narrow off-chip link. The link has one serial lane in each direction, and each lane carries W-bit flits with a valid/ready handshake. On the outbound side a round-robin arbiter picks one of the channels that has a beat waiting. The serializer puts a 3-bit channel header in front of the beat's payload and shifts the result out. On the inbound side the deserializer collects flits until it has a whole beat. It then checks the header and offers the payload on the matching channel.

A role parameter sets which channels may use which lane:

| Role | Outbound lane | Inbound lane |
|------|---------------|--------------|
| manager-facing | A, C, E | B, D |
| client-facing | B, D | A, C, E |
| combined | all five channels | all five channels |

A manager-facing bridge on one die pairs naturally with a client-facing bridge on the other die.

The serializer has two states. TX_IDLE moves to TX_SHIFT when the arbiter has a grant, and the beat is loaded in that same cycle. TX_SHIFT moves back to TX_IDLE when the last flit is accepted on the lane. The deserializer also has two states. RX_COLLECT moves to RX_HOLD when the last flit of a beat with a legal header arrives. If the header is illegal, it stays in RX_COLLECT and sets the error flag. RX_HOLD moves back to RX_COLLECT when the addressed channel asserts ready.

Top module: `bus_serial_bridge`

## Requirements
- R1: With ROLE=0 (manager-facing), only channels A, C and E (indices 0, 2, 4) are sent on the outbound lane, and only B and D (indices 1, 3) are delivered from the inbound lane.
- R2: With ROLE=1 (client-facing), only B and D are sent on the outbound lane, and only A, C and E are delivered from the inbound lane.
- R3: With ROLE=2 (combined), all five channels are sent outbound and all five are delivered inbound. Each channel keeps its beats in order.
- R4: A beat is sent as NF=ceil((3+P)/W) flits. The flits hold, most-significant bit first, the 3-bit channel index (A=0, B=1, C=2, D=3, E=4), then the P-bit payload, then zero padding at the end.
- R5: A channel that may not use the outbound lane in the current role never sees tx_ready, even when its tx_valid is asserted.
- R6: Grants rotate round-robin among the legal channels with a beat pending, starting from channel 0 after reset. A granted beat is sent in full before the next grant, so with the lane always ready, grants come NF+1 cycles apart.
- R7: A beat is accepted only when the shift register is empty (TX_IDLE), and at most one tx_ready bit is high at a time.
- R8: While out_valid is high and out_ready is low, out_valid and out_flit hold their values.
- R9: rx_valid rises only after the last flit of a beat has been taken. The beat's rx_valid and rx_data then hold until the matching rx_ready, and in_ready stays low for that time.
- R10: A beat whose header names a channel that is not legal inbound for the role, or an index of 5 to 7, is dropped without raising rx_valid. err_hdr then goes high and stays high until reset.
- R11: After reset, out_valid, rx_valid and err_hdr are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 5 | Beat pending, one bit per channel (bit 0 = A) |
| tx_ready | output | 5 | Beat accepted, one bit per channel |
| tx_data | input | 5 x P | Payload per channel |
| out_valid | output | 1 | Outbound flit valid |
| out_ready | input | 1 | Outbound lane can take a flit |
| out_flit | output | W | Outbound flit |
| in_valid | input | 1 | Inbound flit valid |
| in_ready | output | 1 | Bridge can take an inbound flit |
| in_flit | input | W | Inbound flit |
| rx_valid | output | 5 | Reassembled beat offered, one bit per channel |
| rx_ready | input | 5 | Channel takes the offered beat |
| rx_data | output | P | Payload of the offered beat |
| err_hdr | output | 1 | Sticky flag: a beat with an illegal header was dropped |

## Verification
The bench places a manager-facing and a client-facing bridge back to back, and loops a combined bridge onto itself. Random traffic runs on all three, and per-channel scoreboards catch lost, duplicated, reordered or misrouted beats. Directed cases cover:

- Grant order with three channels pending. A broken pointer would starve a channel or repeat one.
- Grant spacing. A grant taken in the middle of a beat would break the spacing.
- The exact flit pattern of a known beat. This catches a header that is misplaced or a shift in the wrong direction.
- A lane stall. A shift during the stall would lose flits.
- rx_valid after each flit. A valid that fires one flit early would show here.
- A held beat. A beat that is not held would be overwritten by later flits.
- Headers that are illegal for the role, and the out-of-range index 7. A design that delivers these beats would raise rx_valid, and a flag that is not sticky would clear on the next good beat.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
    localparam int NCH   = 5;
    localparam int HDR_W = 3;

    // channel groups: requests (A, C, E) and responses (B, D)
    localparam logic [NCH-1:0] GRP_REQ = 5'b10101;
    localparam logic [NCH-1:0] GRP_RSP = 5'b01010;

    localparam int ROLE_MGR  = 0;
    localparam int ROLE_CLI  = 1;
    localparam int ROLE_BOTH = 2;

    function automatic logic [NCH-1:0] out_lane_mask(input int role);
        if (role == ROLE_MGR)      return GRP_REQ;
        else if (role == ROLE_CLI) return GRP_RSP;
        else                       return '1;
    endfunction

    function automatic logic [NCH-1:0] in_lane_mask(input int role);
        if (role == ROLE_MGR)      return GRP_RSP;
        else if (role == ROLE_CLI) return GRP_REQ;
        else                       return '1;
    endfunction
endpackage

// File: rtl/bsb_rr_arb.sv
module bsb_rr_arb #(
    parameter int N  = 5,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gidx,
    output logic          any
);
    logic [IW-1:0] last_q;

    // search starts one past the last winner
    always_comb begin
        gnt  = '0;
        gidx = '0;
        any  = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int idx;
            idx = (int'(last_q) + off) % N;
            if (!any && req[idx]) begin
                any      = 1'b1;
                gnt[idx] = 1'b1;
                gidx     = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IW'(N - 1);
        else if (adv && any)
            last_q <= gidx;
    end

    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> any);   // R6
endmodule

// File: rtl/bsb_ser.sv
module bsb_ser
    import bsb_pkg::*;
#(
    parameter int P    = 16,
    parameter int W    = 4,
    parameter int ROLE = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        tx_valid,
    output logic [NCH-1:0]        tx_ready,
    input  logic [NCH-1:0][P-1:0] tx_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [W-1:0]          out_flit
);
    localparam int FRM  = HDR_W + P;
    localparam int NF   = (FRM + W - 1) / W;
    localparam int PADW = NF * W;
    localparam int CW   = (NF > 1) ? $clog2(NF) : 1;
    localparam int IW   = $clog2(NCH);
    localparam logic [NCH-1:0] LEGAL = out_lane_mask(ROLE);

    typedef enum logic {TX_IDLE, TX_SHIFT} tx_st_e;

    tx_st_e          st_q, st_d;
    logic [PADW-1:0] sreg_q;
    logic [CW-1:0]   cnt_q;
    logic [NCH-1:0]  gnt;
    logic [IW-1:0]   gidx;
    logic            any, load, step, last;
    logic [FRM-1:0]  raw;
    logic [PADW-1:0] frame;

    bsb_rr_arb #(.N(NCH), .IW(IW)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (tx_valid & LEGAL),
        .adv  (load),
        .gnt  (gnt),
        .gidx (gidx),
        .any  (any)
    );

    assign last  = (cnt_q == CW'(NF - 1));
    assign raw   = {HDR_W'(gidx), tx_data[gidx]};
    assign frame = PADW'(raw) << (PADW - FRM);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:  if (any) st_d = TX_SHIFT;
            TX_SHIFT: if (out_ready && last) st_d = TX_IDLE;
            default:  st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= TX_IDLE;
            sreg_q <= '0;
            cnt_q  <= '0;
        end else begin
            st_q <= st_d;
            if (load) begin
                sreg_q <= frame;
                cnt_q  <= '0;
            end else if (step) begin
                sreg_q <= sreg_q << W;
                cnt_q  <= cnt_q + CW'(1);
            end
        end
    end

    always_comb begin
        load      = (st_q == TX_IDLE) && any;
        tx_ready  = (st_q == TX_IDLE) ? gnt : '0;
        out_valid = (st_q == TX_SHIFT);
        out_flit  = sreg_q[PADW-1 -: W];
        step      = out_valid && out_ready;
    end

    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_ready));   // R7
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (tx_ready == '0));   // R7
    AST_LEGAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready & ~LEGAL) == '0);   // R5
    AST_FLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));   // R8
endmodule

// File: rtl/bsb_des.sv
module bsb_des
    import bsb_pkg::*;
#(
    parameter int P    = 16,
    parameter int W    = 4,
    parameter int ROLE = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [W-1:0]   in_flit,
    output logic [NCH-1:0] rx_valid,
    input  logic [NCH-1:0] rx_ready,
    output logic [P-1:0]   rx_data,
    output logic           err_hdr
);
    localparam int FRM  = HDR_W + P;
    localparam int NF   = (FRM + W - 1) / W;
    localparam int PADW = NF * W;
    localparam int CW   = (NF > 1) ? $clog2(NF) : 1;
    localparam logic [NCH-1:0] LEGAL = in_lane_mask(ROLE);

    typedef enum logic {RX_COLLECT, RX_HOLD} rx_st_e;

    rx_st_e            st_q, st_d;
    logic [PADW-W-1:0] sreg_q;
    logic [CW-1:0]     cnt_q;
    logic [HDR_W-1:0]  ch_q;
    logic [P-1:0]      data_q;
    logic              err_q;
    logic              take, done, legal;
    logic [PADW-1:0]   full;
    logic [HDR_W-1:0]  hdr;
    logic [P-1:0]      body;
    logic [7:0]        mask8;

    assign take  = in_valid && in_ready;
    assign done  = take && (cnt_q == CW'(NF - 1));
    assign full  = {sreg_q, in_flit};
    assign hdr   = full[PADW-1 -: HDR_W];
    assign body  = full[PADW-HDR_W-1 -: P];
    assign mask8 = 8'(LEGAL);
    assign legal = mask8[hdr];

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_COLLECT: if (done && legal) st_d = RX_HOLD;
            RX_HOLD:    if (rx_ready[ch_q]) st_d = RX_COLLECT;
            default:    st_d = RX_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RX_COLLECT;
            sreg_q <= '0;
            cnt_q  <= '0;
            ch_q   <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (take) begin
                sreg_q <= full[PADW-W-1:0];
                cnt_q  <= done ? '0 : cnt_q + CW'(1);
            end
            if (done && legal) begin
                ch_q   <= hdr;
                data_q <= body;
            end
            if (done && !legal)
                err_q <= 1'b1;
        end
    end

    always_comb begin
        in_ready = (st_q == RX_COLLECT);
        rx_valid = (st_q == RX_HOLD) ? (NCH'(1) << ch_q) : '0;
        rx_data  = data_q;
        err_hdr  = err_q;
    end

    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rx_valid & ~rx_ready)) |=> (rx_valid == $past(rx_valid) && $stable(rx_data)));   // R9
    AST_LANE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_valid) |-> !in_ready);   // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_hdr |=> err_hdr);   // R10
    AST_RX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid & ~LEGAL) == '0);   // R10
endmodule

// File: rtl/bus_serial_bridge.sv
module bus_serial_bridge
    import bsb_pkg::*;
#(
    parameter int P    = 16,
    parameter int W    = 4,
    parameter int ROLE = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        tx_valid,
    output logic [NCH-1:0]        tx_ready,
    input  logic [NCH-1:0][P-1:0] tx_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [W-1:0]          out_flit,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [W-1:0]          in_flit,
    output logic [NCH-1:0]        rx_valid,
    input  logic [NCH-1:0]        rx_ready,
    output logic [P-1:0]          rx_data,
    output logic                  err_hdr
);
    bsb_ser #(.P(P), .W(W), .ROLE(ROLE)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_flit (out_flit)
    );

    bsb_des #(.P(P), .W(W), .ROLE(ROLE)) u_des (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_ready(in_ready),
        .in_flit (in_flit),
        .rx_valid(rx_valid),
        .rx_ready(rx_ready),
        .rx_data (rx_data),
        .err_hdr (err_hdr)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && rx_valid == '0 && !err_hdr && in_ready));   // R11
endmodule

// File: tb/bus_serial_bridge_tb_top.sv
module bus_serial_bridge_tb_top;
    localparam int CLK_NS = 10;
    localparam int P  = 16;
    localparam int W  = 4;
    localparam int NF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic [2:0][4:0]       txv;
    logic [2:0][4:0][15:0] txd;
    logic [2:0][4:0]       rxr;
    wire  [2:0][4:0]       txr;
    wire  [2:0][4:0]       rxv;
    wire  [2:0][15:0]      rxd;
    wire  [2:0]            ov, orr, iv, ir, err;
    wire  [2:0][3:0]       ofl, ifl;
    logic                  inj_on, inj_v;
    logic [3:0]            inj_f;

    // link: 0 = manager-facing, 1 = client-facing, 2 = combined loopback
    assign iv[0]  = ov[1];
    assign ifl[0] = ofl[1];
    assign orr[1] = ir[0];
    assign iv[1]  = inj_on ? inj_v : ov[0];
    assign ifl[1] = inj_on ? inj_f : ofl[0];
    assign orr[0] = inj_on ? 1'b0 : ir[1];
    assign iv[2]  = ov[2];
    assign ifl[2] = ofl[2];
    assign orr[2] = ir[2];

    bus_serial_bridge #(.P(P), .W(W), .ROLE(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_valid(txv[0]), .tx_ready(txr[0]), .tx_data(txd[0]),
        .out_valid(ov[0]), .out_ready(orr[0]), .out_flit(ofl[0]),
        .in_valid(iv[0]), .in_ready(ir[0]), .in_flit(ifl[0]),
        .rx_valid(rxv[0]), .rx_ready(rxr[0]), .rx_data(rxd[0]), .err_hdr(err[0]));
    bus_serial_bridge #(.P(P), .W(W), .ROLE(1)) dut_c (
        .clk(clk), .rst_n(rst_n), .tx_valid(txv[1]), .tx_ready(txr[1]), .tx_data(txd[1]),
        .out_valid(ov[1]), .out_ready(orr[1]), .out_flit(ofl[1]),
        .in_valid(iv[1]), .in_ready(ir[1]), .in_flit(ifl[1]),
        .rx_valid(rxv[1]), .rx_ready(rxr[1]), .rx_data(rxd[1]), .err_hdr(err[1]));
    bus_serial_bridge #(.P(P), .W(W), .ROLE(2)) dut_b (
        .clk(clk), .rst_n(rst_n), .tx_valid(txv[2]), .tx_ready(txr[2]), .tx_data(txd[2]),
        .out_valid(ov[2]), .out_ready(orr[2]), .out_flit(ofl[2]),
        .in_valid(iv[2]), .in_ready(ir[2]), .in_flit(ifl[2]),
        .rx_valid(rxv[2]), .rx_ready(rxr[2]), .rx_data(rxd[2]), .err_hdr(err[2]));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [2:0][4:0] fired;
    logic [15:0] sbq [15][$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] out_mask(input int d);
        if (d == 0)      return 5'b10101;
        else if (d == 1) return 5'b01010;
        else             return 5'b11111;
    endfunction

    function automatic logic [4:0] in_mask(input int d);
        if (d == 0)      return 5'b01010;
        else if (d == 1) return 5'b10101;
        else             return 5'b11111;
    endfunction

    function automatic int src_of(input int d);
        return (d == 0) ? 1 : ((d == 1) ? 0 : 2);
    endfunction

    function automatic string tag_of(input int d);
        return (d == 0) ? "R1" : ((d == 1) ? "R2" : "R3");
    endfunction

    function automatic logic [3:0] flit_of(input logic [2:0] h, input logic [15:0] dat, input int k);
        logic [19:0] f;
        f = {h, dat, 1'b0};
        return f[19 - 4*k -: 4];
    endfunction

    function automatic int rr_next(input int last, input logic [4:0] pend);
        for (int off = 1; off <= 5; off++) begin
            int idx;
            idx = (last + off) % 5;
            if (pend[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic do_reset();
        rst_n  = 1'b0;
        txv    = '0;
        txd    = '0;
        rxr    = '0;
        inj_on = 1'b0;
        inj_v  = 1'b0;
        inj_f  = '0;
        fired  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_flit(input logic [3:0] f);
        @(negedge clk);
        inj_v = 1'b1;
        inj_f = f;
        #(CLK_NS/4);
        chk(ir[1] == 1'b1, "R9", "in_ready while collecting", 32'(ir[1]), 1);
        @(negedge clk);
        inj_v = 1'b0;
    endtask

    task automatic send_beat(input logic [2:0] h, input logic [15:0] dat);
        for (int k = 0; k < NF; k++) send_flit(flit_of(h, dat, k));
    endtask

    task automatic sample_all();
        for (int d = 0; d < 3; d++) begin
            logic [4:0] om, im;
            om = out_mask(d);
            im = in_mask(d);
            for (int c = 0; c < 5; c++) begin
                fired[d][c] = txv[d][c] && txr[d][c];
                if (txv[d][c] && !om[c])
                    chk(!txr[d][c], "R5", "illegal outbound channel accepted", 32'(txr[d]), 0);
                else if (fired[d][c])
                    sbq[d*5 + c].push_back(txd[d][c]);
                if (rxv[d][c] && rxr[d][c]) begin
                    int s;
                    s = src_of(d);
                    chk(im[c], tag_of(d), "inbound channel legality", 32'(c), 32'(im));
                    if (sbq[s*5 + c].size() == 0)
                        chk(1'b0, tag_of(s), "unexpected beat", 32'(rxd[d]), 0);
                    else begin
                        logic [15:0] e;
                        e = sbq[s*5 + c].pop_front();
                        chk(rxd[d] == e, tag_of(s), "routed payload", 32'(rxd[d]), 32'(e));
                    end
                end
            end
        end
    endtask

    task automatic rand_cycles(input int n, input bit gen);
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            for (int d = 0; d < 3; d++) begin
                logic [4:0] om;
                om = out_mask(d);
                for (int c = 0; c < 5; c++) begin
                    if (!gen && !om[c])
                        txv[d][c] = 1'b0;
                    else if (fired[d][c] || !txv[d][c]) begin
                        if (gen && ($urandom % 3) != 0) begin
                            txv[d][c] = 1'b1;
                            txd[d][c] = 16'($urandom);
                        end else
                            txv[d][c] = 1'b0;
                    end
                end
                rxr[d] = gen ? 5'($urandom | $urandom) : 5'h1f;
            end
            #(CLK_NS/4);
            sample_all();
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R6 watchdog expired act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int lastg, lastt, nfire;
        void'($urandom(32'h5eed_1234));
        do_reset();

        // R11: reset state
        @(negedge clk);
        #(CLK_NS/4);
        chk(ov == 3'b000, "R11", "out_valid after reset", 32'(ov), 0);
        chk(rxv == '0, "R11", "rx_valid after reset", 32'(rxv), 0);
        chk(err == 3'b000, "R11", "err_hdr after reset", 32'(err), 0);
        chk(ir == 3'b111, "R11", "in_ready after reset", 32'(ir), 32'h7);

        // R6: round-robin order and full-beat spacing on the manager side
        do_reset();
        rxr[1] = 5'h1f;
        lastg = 4;
        lastt = -1;
        nfire = 0;
        for (int t = 0; t < 200 && nfire < 6; t++) begin
            @(negedge clk);
            for (int c = 0; c < 5; c++) begin
                txv[0][c] = (c != 3);
                if (fired[0][c]) txd[0][c] = 16'($urandom);
            end
            #(CLK_NS/4);
            fired[0] = txv[0] & txr[0];
            chk(!txr[0][1], "R5", "channel B granted on manager outbound", 32'(txr[0]), 0);
            for (int c = 0; c < 5; c++) begin
                if (fired[0][c]) begin
                    int e;
                    e = rr_next(lastg, 5'b10101);
                    chk(c == e, "R6", "grant order", 32'(c), 32'(e));
                    if (lastt >= 0)
                        chk(t - lastt == NF + 1, "R6", "grant spacing", 32'(t - lastt), NF + 1);
                    lastg = c;
                    lastt = t;
                    nfire++;
                end
            end
        end
        chk(nfire == 6, "R6", "grant count", 32'(nfire), 6);

        // R4, R7, R8: flit pattern, accept only when empty, stall hold
        do_reset();
        inj_on = 1'b1;
        @(negedge clk);
        txv[0][0] = 1'b1;
        txd[0][0] = 16'hA5C3;
        #(CLK_NS/4);
        chk(txr[0][0], "R7", "accept when idle", 32'(txr[0]), 1);
        @(negedge clk);
        txv[0][0] = 1'b0;
        txv[0][2] = 1'b1;
        txd[0][2] = 16'h0001;
        for (int k = 0; k < 3; k++) begin
            #(CLK_NS/4);
            chk(ov[0] && ofl[0] == flit_of(3'd0, 16'hA5C3, 0), "R8", "stalled flit",
                32'(ofl[0]), 32'(flit_of(3'd0, 16'hA5C3, 0)));
            chk(txr[0] == '0, "R7", "no accept while shifting", 32'(txr[0]), 0);
            @(negedge clk);
        end
        txv[0][2] = 1'b0;
        inj_on = 1'b0;
        begin
            int k;
            k = 0;
            for (int g = 0; g < 20 && k < NF; g++) begin
                #(CLK_NS/4);
                if (ov[0] && orr[0]) begin
                    chk(ofl[0] == flit_of(3'd0, 16'hA5C3, k), "R4", "flit content",
                        32'(ofl[0]), 32'(flit_of(3'd0, 16'hA5C3, k)));
                    k++;
                end
                @(negedge clk);
            end
            chk(k == NF, "R4", "flit count", 32'(k), NF);
        end
        @(negedge clk);
        chk(rxv[1] == 5'b00001 && rxd[1] == 16'hA5C3, "R1", "A delivered to client side",
            32'(rxd[1]), 32'hA5C3);

        // R9, R10: deserializer timing, hold, illegal headers
        do_reset();
        inj_on = 1'b1;
        for (int k = 0; k < NF - 1; k++) begin
            send_flit(flit_of(3'd0, 16'h1234, k));
            chk(rxv[1] == '0, "R9", "rx_valid before last flit", 32'(rxv[1]), 0);
        end
        send_flit(flit_of(3'd0, 16'h1234, NF - 1));
        chk(rxv[1] == 5'b00001 && rxd[1] == 16'h1234, "R9", "beat after last flit",
            32'(rxd[1]), 32'h1234);
        repeat (3) @(negedge clk);
        chk(rxv[1] == 5'b00001 && rxd[1] == 16'h1234, "R9", "beat held", 32'(rxv[1]), 1);
        chk(ir[1] == 1'b0, "R9", "in_ready low while holding", 32'(ir[1]), 0);
        rxr[1] = 5'b00001;
        @(negedge clk);
        rxr[1] = '0;
        chk(rxv[1] == '0, "R9", "released after ready", 32'(rxv[1]), 0);
        send_beat(3'd1, 16'hBEEF);
        chk(rxv[1] == '0, "R10", "channel B dropped on client inbound", 32'(rxv[1]), 0);
        chk(err[1] == 1'b1, "R10", "error flag set", 32'(err[1]), 1);
        send_beat(3'd7, 16'h5555);
        chk(rxv[1] == '0, "R10", "index 7 dropped", 32'(rxv[1]), 0);
        send_beat(3'd4, 16'h0F0F);
        chk(rxv[1] == 5'b10000 && rxd[1] == 16'h0F0F, "R2", "E delivered on client inbound",
            32'(rxd[1]), 32'h0F0F);
        chk(err[1] == 1'b1, "R10", "error flag sticky", 32'(err[1]), 1);
        chk(err[0] == 1'b0 && err[2] == 1'b0, "R10", "no error on other bridges", 32'(err), 0);

        // R1, R2, R3: random traffic through all bridges
        do_reset();
        @(negedge clk);
        chk(err[1] == 1'b0, "R10", "error flag cleared by reset", 32'(err[1]), 0);
        rand_cycles(3000, 1'b1);
        rand_cycles(200, 1'b0);
        for (int s = 0; s < 3; s++)
            for (int c = 0; c < 5; c++)
                chk(sbq[s*5 + c].size() == 0, tag_of(s), "beats left undelivered",
                    32'(sbq[s*5 + c].size()), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule